// File: doc/BRIEF.md
# SPI FIFO Data Register Packing

This block connects a 32-bit register bus to the transmit and receive word FIFOs of an SPI master. On the transmit side, one bus write places one or two serial words into the transmit FIFO. The number of words depends on the packing mode and on the byte strobes. On the receive side, each bus read takes one word from the receive FIFO. The read returns that word together with the number of the peripheral chip select it arrived on. Because every receive entry carries this tag, a read never returns more than one word.

Both FIFOs count their contents in words, not bytes. The active word width can be set anywhere from 8 to 16 bits, and bits above that width are cleared before a word is stored. Each FIFO can be emptied in one cycle by its own clear command. Software issues these clears while setting up, before the serial engine is enabled.

The serial shifter sits on the far side of the FIFOs. It takes transmit words through a pop strobe and delivers receive words through a push strobe. The block reports the fill level, full and empty for each FIFO, plus sticky overflow and underrun flags.

Top module: `spi_dreg_pack`

## Requirements
- R1: After reset both FIFOs are empty with level 0, all sticky flags are clear, and `rd_data` and `tx_word` read 0.
- R2: With `cfg_multi` low, a bus write with any byte strobe set pushes exactly one word, taken from `wr_data[15:0]`.
- R3: With `cfg_multi` high, a write with any strobe in `wr_be[3:2]` set pushes two words: first `wr_data[15:0]`, then `wr_data[31:16]`. A write with only `wr_be[1:0]` set pushes one word from bits 15:0. A write with no strobe set pushes nothing.
- R4: Every stored word, transmit or receive, keeps only its low W bits. W is `cfg_width` clamped to the range 8..16. This holds even in two-word mode at width 8, where the words are `wr_data[7:0]` and `wr_data[23:16]`.
- R5: A FIFO accepts exactly DEPTH words at any width, and `*_full` is high exactly when its level equals DEPTH.
- R6: A transmit push that finds no free slot drops the word and sets `tx_ovf`. A two-word write with a single free slot keeps the first word and drops the second. `tx_ovf` stays set until `tx_clr`.
- R7: `tx_word` presents the oldest transmit word and `tx_pop` removes it, so words leave in write order. A pop on an empty FIFO has no effect.
- R8: One cycle after `rd_en`, `rd_data` holds the oldest receive entry: the word in bits 15:0, the chip-select tag in bits 16+CSW-1:16, and zeros above. Each read removes exactly one entry, in arrival order.
- R9: An `rx_push` while the receive FIFO is full is dropped and sets `rx_ovf`, which stays set until `rx_clr`.
- R10: A read from an empty receive FIFO returns 0 and sets `rx_unf`, which stays set until `rx_clr`.
- R11: `tx_clr` empties the transmit FIFO in the next cycle, clears `tx_ovf`, and discards a write made in the same cycle. `rx_clr` empties the receive FIFO and clears `rx_ovf` and `rx_unf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_multi | input | 1 | Two-words-per-write packing mode |
| cfg_width | input | 5 | Word width in bits, clamped to 8..16 |
| tx_clr | input | 1 | Empty the transmit FIFO |
| rx_clr | input | 1 | Empty the receive FIFO |
| wr_en | input | 1 | Bus write to the transmit data register |
| wr_be | input | 4 | Byte strobes of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Bus read of the receive data register |
| rd_data | output | 32 | Registered read result: tag and word |
| tx_pop | input | 1 | Shifter takes the oldest transmit word |
| tx_word | output | 16 | Oldest transmit word, 0 when empty |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_cs | input | CSW | Chip-select number of the received word |
| rx_word | input | 16 | Received word |
| tx_level | output | LW | Transmit FIFO fill level in words |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_level | output | LW | Receive FIFO fill level in words |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_unf | output | 1 | Sticky receive underrun |

## Verification
The bench builds the block with DEPTH set to 4 and CSW set to 4. At this depth the bench can fill either FIFO in a handful of writes. That brings three cases within reach: full, drop on full, and a two-word write that finds exactly one slot free. A 4-bit tag gives room to use several distinct chip-select values, so the bench can see that each tag stays with its own word through the receive FIFO.

// File: rtl/spi_dreg_pack_pkg.sv
package spi_dreg_pack_pkg;

    localparam int MIN_W = 8;
    localparam int MAX_W = 16;

    // Mask that keeps the low bits of a word for the configured width.
    function automatic logic [15:0] width_mask(input logic [4:0] w);
        int eff;
        eff = int'(w);
        if (eff < MIN_W) eff = MIN_W;
        if (eff > MAX_W) eff = MAX_W;
        return 16'hFFFF >> (MAX_W - eff);
    endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [1:0]    push_cnt,
    input  logic [W-1:0]  d0,
    input  logic [W-1:0]  d1,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [LW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.wptr = st_q.wptr + AW'(push_cnt);
            st_d.rptr = st_q.rptr + AW'(pop);
            st_d.cnt  = st_q.cnt + LW'(push_cnt) - LW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!clr) begin
            if (push_cnt != 2'd0) mem[st_q.wptr] <= d0;
            if (push_cnt == 2'd2) mem[AW'(st_q.wptr + AW'(1))] <= d1;
        end
    end

    assign head  = mem[st_q.rptr];
    assign level = st_q.cnt;

endmodule

// File: rtl/spi_dreg_pack.sv
module spi_dreg_pack
    import spi_dreg_pack_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CSW   = 4,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_multi,
    input  logic [4:0]     cfg_width,
    input  logic           tx_clr,
    input  logic           rx_clr,
    input  logic           wr_en,
    input  logic [3:0]     wr_be,
    input  logic [31:0]    wr_data,
    input  logic           rd_en,
    output logic [31:0]    rd_data,
    input  logic           tx_pop,
    output logic [15:0]    tx_word,
    input  logic           rx_push,
    input  logic [CSW-1:0] rx_cs,
    input  logic [15:0]    rx_word,
    output logic [LW-1:0]  tx_level,
    output logic           tx_full,
    output logic           tx_empty,
    output logic           tx_ovf,
    output logic [LW-1:0]  rx_level,
    output logic           rx_full,
    output logic           rx_empty,
    output logic           rx_ovf,
    output logic           rx_unf
);

    localparam int RXW = 16 + CSW;

    typedef struct packed {
        logic        tx_ovf;
        logic        rx_ovf;
        logic        rx_unf;
        logic [31:0] rd_data;
    } pack_st_t;

    pack_st_t st_d, st_q;

    logic [15:0]    mask;
    logic [1:0]     want;
    logic [1:0]     tx_take;
    logic [LW-1:0]  tx_free;
    logic           tx_pop_ok;
    logic           rx_take;
    logic           rd_take;
    logic [15:0]    tx_head;
    logic [RXW-1:0] rx_head;

    assign mask    = width_mask(cfg_width);
    assign tx_free = LW'(DEPTH) - tx_level;

    always_comb begin
        // words requested by this write
        if (!wr_en || wr_be == 4'b0000)      want = 2'd0;
        else if (cfg_multi && |wr_be[3:2])   want = 2'd2;
        else                                 want = 2'd1;

        if (tx_clr)                          tx_take = 2'd0;
        else if (LW'(want) <= tx_free)       tx_take = want;
        else                                 tx_take = tx_free[1:0];

        tx_pop_ok = tx_pop && !tx_empty && !tx_clr;
        rx_take   = rx_push && !rx_full && !rx_clr;
        rd_take   = rd_en && !rx_empty && !rx_clr;

        st_d = st_q;
        st_d.tx_ovf = tx_clr ? 1'b0 : (st_q.tx_ovf || (LW'(want) > tx_free));
        st_d.rx_ovf = rx_clr ? 1'b0 : (st_q.rx_ovf || (rx_push && rx_full));
        st_d.rx_unf = rx_clr ? 1'b0 : (st_q.rx_unf || (rd_en && rx_empty));
        if (rd_en) begin
            if (rd_take) st_d.rd_data = 32'(rx_head);
            else         st_d.rd_data = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    spi_word_fifo #(.DEPTH(DEPTH), .W(16)) u_txf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tx_clr),
        .push_cnt (tx_take),
        .d0       (wr_data[15:0] & mask),
        .d1       (wr_data[31:16] & mask),
        .pop      (tx_pop_ok),
        .head     (tx_head),
        .level    (tx_level)
    );

    spi_word_fifo #(.DEPTH(DEPTH), .W(RXW)) u_rxf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_clr),
        .push_cnt ({1'b0, rx_take}),
        .d0       ({rx_cs, rx_word & mask}),
        .d1       ('0),
        .pop      (rd_take),
        .head     (rx_head),
        .level    (rx_level)
    );

    assign tx_full  = (tx_level == LW'(DEPTH));
    assign tx_empty = (tx_level == '0);
    assign rx_full  = (rx_level == LW'(DEPTH));
    assign rx_empty = (rx_level == '0);
    assign tx_word  = tx_empty ? 16'h0 : tx_head;
    assign tx_ovf   = st_q.tx_ovf;
    assign rx_ovf   = st_q.rx_ovf;
    assign rx_unf   = st_q.rx_unf;
    assign rd_data  = st_q.rd_data;

endmodule

// File: rtl/spi_dreg_pack_chk.sv
module spi_dreg_pack_chk #(
    parameter int DEPTH = 8,
    parameter int CSW   = 4,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_multi,
    input logic          tx_clr,
    input logic          rx_clr,
    input logic          wr_en,
    input logic [3:0]    wr_be,
    input logic          rd_en,
    input logic [31:0]   rd_data,
    input logic          tx_pop,
    input logic          rx_push,
    input logic [LW-1:0] tx_level,
    input logic          tx_full,
    input logic          tx_empty,
    input logic          tx_ovf,
    input logic [LW-1:0] rx_level,
    input logic          rx_full,
    input logic          rx_empty,
    input logic          rx_ovf,
    input logic          rx_unf
);

    AST_LEVEL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH)); // R5

    AST_TWO_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_multi && wr_en && |wr_be[3:2] && tx_level <= LW'(DEPTH - 2) && !tx_pop && !tx_clr
        |=> tx_level == $past(tx_level) + LW'(2)); // R3

    AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full && wr_en && wr_be != 4'b0000 && !tx_pop && !tx_clr
        |=> tx_ovf && tx_level == LW'(DEPTH)); // R6

    AST_TX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf && !tx_clr |=> tx_ovf); // R6

    AST_RX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_full && !rx_clr |=> rx_ovf); // R9

    AST_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rx_empty && !rx_clr |=> rx_unf && rd_data == 32'h0); // R10

    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> tx_empty && !tx_ovf); // R11

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> rx_empty && !rx_ovf && !rx_unf); // R11

endmodule

bind spi_dreg_pack spi_dreg_pack_chk #(.DEPTH(DEPTH), .CSW(CSW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_multi (cfg_multi),
    .tx_clr    (tx_clr),
    .rx_clr    (rx_clr),
    .wr_en     (wr_en),
    .wr_be     (wr_be),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .tx_pop    (tx_pop),
    .rx_push   (rx_push),
    .tx_level  (tx_level),
    .tx_full   (tx_full),
    .tx_empty  (tx_empty),
    .tx_ovf    (tx_ovf),
    .rx_level  (rx_level),
    .rx_full   (rx_full),
    .rx_empty  (rx_empty),
    .rx_ovf    (rx_ovf),
    .rx_unf    (rx_unf)
);

// File: tb/spi_dreg_pack_bench.sv
`timescale 1ns/1ps
module spi_dreg_pack_bench;

    localparam int DEPTH = 4;
    localparam int CSW   = 4;
    localparam int LW    = $clog2(DEPTH) + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_multi = 1'b0;
    logic [4:0]     cfg_width = 5'd16;
    logic           tx_clr = 1'b0, rx_clr = 1'b0;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_be = 4'h0;
    logic [31:0]    wr_data = 32'h0;
    logic           rd_en = 1'b0;
    logic [31:0]    rd_data;
    logic           tx_pop = 1'b0;
    logic [15:0]    tx_word;
    logic           rx_push = 1'b0;
    logic [CSW-1:0] rx_cs = '0;
    logic [15:0]    rx_word = 16'h0;
    logic [LW-1:0]  tx_level, rx_level;
    logic           tx_full, tx_empty, tx_ovf, rx_full, rx_empty, rx_ovf, rx_unf;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;
    bit rd_seen = 0;

    logic [15:0] tx_q[$];
    logic [31:0] rx_q[$];
    logic [31:0] rd_exp[$];
    string       rd_tag[$];

    always #2 clk = ~clk;

    spi_dreg_pack #(.DEPTH(DEPTH), .CSW(CSW)) u_spi_dreg_pack (
        .clk(clk), .rst_n(rst_n), .cfg_multi(cfg_multi), .cfg_width(cfg_width),
        .tx_clr(tx_clr), .rx_clr(rx_clr), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .tx_pop(tx_pop),
        .tx_word(tx_word), .rx_push(rx_push), .rx_cs(rx_cs), .rx_word(rx_word),
        .tx_level(tx_level), .tx_full(tx_full), .tx_empty(tx_empty), .tx_ovf(tx_ovf),
        .rx_level(rx_level), .rx_full(rx_full), .rx_empty(rx_empty), .rx_ovf(rx_ovf),
        .rx_unf(rx_unf)
    );

    function automatic logic [15:0] bmask(input logic [4:0] w);
        int e;
        e = (w < 8) ? 8 : ((w > 16) ? 16 : int'(w));
        return 16'((32'h1 << e) - 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: model the expected transmit words, then drive the write
    task automatic send(input logic [31:0] d, input logic [3:0] be);
        int n;
        logic [15:0] w [2];
        w[0] = d[15:0] & bmask(cfg_width);
        w[1] = d[31:16] & bmask(cfg_width);
        n = (be == 4'h0) ? 0 : ((cfg_multi && (be[3] || be[2])) ? 2 : 1);
        for (int i = 0; i < n; i++)
            if (tx_q.size() < DEPTH) tx_q.push_back(w[i]);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0;
    endtask

    // compare the oldest transmit word with the queue, then pop it
    task automatic drain(input string req);
        while (tx_q.size() > 0) begin
            chk(req, 32'(tx_word), 32'(tx_q.pop_front()));
            tx_pop = 1'b1;
            @(negedge clk);
            tx_pop = 1'b0;
        end
        chk(req, 32'(tx_empty), 32'h1);
    endtask

    task automatic rx_send(input logic [CSW-1:0] cs, input logic [15:0] w);
        if (rx_q.size() < DEPTH) rx_q.push_back({12'h0, cs, w & bmask(cfg_width)});
        @(negedge clk);
        rx_push = 1'b1; rx_cs = cs; rx_word = w;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic rx_read(input string req);
        if (rx_q.size() == 0) begin
            rd_exp.push_back(32'h0); rd_tag.push_back("R10");
        end else begin
            rd_exp.push_back(rx_q.pop_front()); rd_tag.push_back(req);
        end
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: result of a read is visible one cycle after rd_en
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (rd_exp.size() == 0) chk("R8", rd_data, 32'hDEAD_BEEF);
            else chk(rd_tag.pop_front(), rd_data, rd_exp.pop_front());
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", 32'(tx_level), 0); chk("R1", 32'(rx_level), 0);
        chk("R1", {29'h0, tx_empty, rx_empty, tx_full | rx_full}, 32'h6);
        chk("R1", {29'h0, tx_ovf, rx_ovf, rx_unf}, 0);
        chk("R1", rd_data, 0); chk("R1", 32'(tx_word), 0);

        // R2 single mode
        send(32'hABCD_1234, 4'hF);
        chk("R2", 32'(tx_level), 1);
        drain("R2");

        // R3 multiple mode strobes
        cfg_multi = 1'b1;
        send(32'hBEEF_CAFE, 4'hF);
        chk("R3", 32'(tx_level), 2);
        drain("R3");
        send(32'h1234_5678, 4'b0011);
        chk("R3", 32'(tx_level), 1);
        send(32'h9999_9999, 4'b0000);
        chk("R3", 32'(tx_level), 1);
        drain("R3");

        // R4 width masking and clamping
        cfg_width = 5'd8;
        send(32'h1234_5678, 4'hF);
        drain("R4");
        cfg_multi = 1'b0; cfg_width = 5'd3;
        send(32'hFFFF_FFFF, 4'hF);
        drain("R4");
        cfg_width = 5'd20;
        send(32'h0001_FFFF, 4'hF);
        drain("R4");

        // R5 capacity, R6 overflow, R7 order
        cfg_width = 5'd16;
        for (int i = 0; i < DEPTH; i++) send(32'h100 + 32'(i), 4'h1);
        chk("R5", 32'(tx_full), 1); chk("R5", 32'(tx_level), DEPTH);
        chk("R6", 32'(tx_ovf), 0);
        send(32'h0000_0777, 4'h1);
        chk("R6", 32'(tx_ovf), 1); chk("R6", 32'(tx_level), DEPTH);
        drain("R7");
        tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
        chk("R7", 32'(tx_level), 0);
        chk("R6", 32'(tx_ovf), 1);

        // R6 two-word write with one free slot
        cfg_multi = 1'b1;
        send(32'h0000_1111, 4'b0011);
        send(32'h0000_2222, 4'b0011);
        send(32'h0000_3333, 4'b0011);
        send(32'h5555_4444, 4'hF);
        chk("R6", 32'(tx_level), DEPTH);
        drain("R6");

        // R11 transmit clear with a same-cycle write
        send(32'h0000_6666, 4'b0011);
        tx_q.delete();
        @(negedge clk);
        tx_clr = 1'b1; wr_en = 1'b1; wr_be = 4'hF; wr_data = 32'hAAAA_BBBB;
        @(negedge clk);
        tx_clr = 1'b0; wr_en = 1'b0; wr_be = 4'h0;
        chk("R11", 32'(tx_level), 0); chk("R11", 32'(tx_ovf), 0);

        // R8 receive reads with tags
        rx_send(4'd3, 16'hABCD);
        rx_send(4'd1, 16'h1234);
        rx_send(4'd0, 16'hFFFF);
        chk("R8", 32'(rx_level), 3);
        rx_read("R8"); rx_read("R8"); rx_read("R8");
        @(negedge clk);
        chk("R8", 32'(rx_empty), 1);

        // R10 underrun
        rx_read("R10");
        @(negedge clk);
        chk("R10", 32'(rx_unf), 1);

        // R4 receive masking
        cfg_width = 5'd8;
        rx_send(4'd2, 16'h01FF);
        rx_read("R4");
        cfg_width = 5'd16;

        // R9 receive overflow
        for (int i = 0; i < DEPTH; i++) rx_send(CSW'(i + 4), 16'h0A00 + 16'(i));
        chk("R5", 32'(rx_full), 1);
        rx_send(4'd9, 16'h0BAD);
        chk("R9", 32'(rx_ovf), 1); chk("R9", 32'(rx_level), DEPTH);
        for (int i = 0; i < DEPTH; i++) rx_read("R9");
        @(negedge clk);
        chk("R9", 32'(rx_empty), 1);

        // R11 receive clear
        rx_send(4'd1, 16'h0101);
        rx_send(4'd2, 16'h0202);
        rx_q.delete();
        @(negedge clk);
        rx_clr = 1'b1;
        @(negedge clk);
        rx_clr = 1'b0;
        chk("R11", 32'(rx_level), 0);
        chk("R11", {29'h0, rx_ovf, rx_unf, 1'b0}, 0);
        rx_read("R10");
        @(negedge clk);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule